// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an on-chip requester and an external asynchronous static RAM of 524,288 bytes. A requester presents a 19-bit word address, a direction flag and write data for one clock while the block is idle. The block then drives the memory's active-low chip-select, output-enable and write-strobe pins, the address lines and a three-state 8-bit data bus. It holds each phase for a parameterised number of system clocks, so the memory's minimum pulse and cycle times are met at the chosen clock period.

Reads hold chip-select and output-enable low for a programmed wait. The data bus is sampled on the clock edge that ends that wait, and a one-cycle valid pulse is raised. Writes use the write strobe to time the transfer, and output-enable stays high throughout. The address is latched once at acceptance and does not move until the memory is back in standby. A done pulse marks the return to idle, and the idle state keeps all three strobes high, so the memory stays in standby between accesses.

Top module: `sram_seq`

## Requirements
- R1: After reset, and in every cycle while `busy` is low, `ram_cs_n`, `ram_oe_n` and `ram_we_n` are all 1.
- R2: `ram_addr` never changes between two consecutive cycles in which both `ram_cs_n` and `ram_we_n` are 0.
- R3: During a write, `ram_oe_n` stays 1. `ram_we_n` falls only after `ram_cs_n` has already been 0 for one cycle.
- R4: A write stores `req_wdata` at `req_addr`. The block drives `ram_dq` only while `ram_cs_n` is 0 and `ram_oe_n` is 1.
- R5: In each write, `ram_we_n` is 0 for exactly WR_PULSE consecutive cycles.
- R6: For a read, `rd_valid` is 1 in the cycle that starts RD_WAIT clock edges after the accepting edge. `rd_data` then equals the memory byte at the requested address.
- R7: `rd_valid` is high for a single cycle. In that cycle `ram_oe_n` has just returned to 1.
- R8: A `req_valid` that arrives while `busy` is 1 is ignored. No access is made to its address and no data is stored.
- R9: `done` pulses high for one cycle as each access returns to idle. For a read, this happens TURN cycles after the `rd_valid` cycle.
- R10: The wait counts multiplied by CLK_PS must cover the minimum access, pulse, setup and float times given as parameters. This is checked at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 8 | Captured read byte |
| ram_cs_n | output | 1 | Memory chip select, active low |
| ram_oe_n | output | 1 | Memory output enable, active low |
| ram_we_n | output | 1 | Memory write strobe, active low |
| ram_addr | output | 19 | Memory address |
| ram_dq | inout | 8 | Memory data bus, three-state |

## Verification
The bound checker watches the strobe relations in every cycle:
- standby while idle;
- no address motion inside a write overlap;
- output-enable high whenever the write strobe is low;
- the block's data driver active only with output-enable high;
- the write strobe falling only after a chip-select setup cycle;
- single-cycle valid and done pulses.

Some properties can only be shown by the directed scenarios against a behavioural memory:
- that stored and returned bytes match;
- the exact read latency and write-pulse length;
- the use of the top address bit;
- that a request made while busy leaves the memory untouched.

// File: rtl/sram_seq.sv
module sram_seq #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 8000,
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 1,
  parameter int TURN     = 1,
  parameter int T_AA_PS  = 8000,
  parameter int T_RC_PS  = 8000,
  parameter int T_WP_PS  = 7000,
  parameter int T_AW_PS  = 7000,
  parameter int T_DW_PS  = 5500,
  parameter int T_HZ_PS  = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [ADDR_W-1:0] ram_addr,
  inout  wire  [DATA_W-1:0] ram_dq
);
  localparam int MAXC = (RD_WAIT > WR_PULSE) ? ((RD_WAIT > TURN) ? RD_WAIT : TURN)
                                             : ((WR_PULSE > TURN) ? WR_PULSE : TURN);
  localparam int CW = $clog2(MAXC + 1) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_RTURN, ST_WSET, ST_WPULSE, ST_WEND
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [DATA_W-1:0] wdat_q;
  logic drv_en;

  assign busy   = (st != ST_IDLE);
  assign ram_dq = drv_en ? wdat_q : {DATA_W{1'bz}};

  always_comb begin
    nxt     = st;
    cnt_nxt = cnt;
    unique case (st)
      ST_IDLE:
        if (req_valid) begin
          nxt     = req_write ? ST_WSET : ST_READ;
          cnt_nxt = CW'(RD_WAIT - 1);
        end
      ST_READ:
        if (cnt == '0) begin
          nxt     = ST_RTURN;
          cnt_nxt = CW'(TURN - 1);
        end else cnt_nxt = cnt - 1'b1;
      ST_RTURN:
        if (cnt == '0) nxt = ST_IDLE;
        else cnt_nxt = cnt - 1'b1;
      ST_WSET: begin
        nxt     = ST_WPULSE;
        cnt_nxt = CW'(WR_PULSE - 1);
      end
      ST_WPULSE:
        if (cnt == '0) nxt = ST_WEND;
        else cnt_nxt = cnt - 1'b1;
      ST_WEND: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ram_cs_n <= 1'b1;
      ram_oe_n <= 1'b1;
      ram_we_n <= 1'b1;
      drv_en   <= 1'b0;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ram_addr <= '0;
      wdat_q   <= '0;
    end else begin
      st       <= nxt;
      cnt      <= cnt_nxt;
      ram_cs_n <= (nxt == ST_IDLE) || (nxt == ST_RTURN);
      ram_oe_n <= (nxt != ST_READ);
      ram_we_n <= (nxt != ST_WPULSE);
      drv_en   <= (nxt == ST_WPULSE) || (nxt == ST_WEND);
      done     <= (st != ST_IDLE) && (nxt == ST_IDLE);
      rd_valid <= (st == ST_READ) && (nxt == ST_RTURN);
      if (st == ST_READ && nxt == ST_RTURN) rd_data <= ram_dq;
      if (st == ST_IDLE && req_valid) begin
        ram_addr <= req_addr;
        wdat_q   <= req_wdata;
      end
    end
  end
endmodule

module sram_seq_chk #(
  parameter int ADDR_W = 19, parameter int CLK_PS = 8000,
  parameter int RD_WAIT = 2, parameter int WR_PULSE = 1, parameter int TURN = 1,
  parameter int T_AA_PS = 8000, parameter int T_RC_PS = 8000, parameter int T_WP_PS = 7000,
  parameter int T_AW_PS = 7000, parameter int T_DW_PS = 5500, parameter int T_HZ_PS = 4000
) (
  input logic clk, rst_n, busy, done, rd_valid, ram_cs_n, ram_oe_n, ram_we_n, drv_en,
  input logic [ADDR_W-1:0] ram_addr
);
  initial begin
    a_r10_read_wait:  assert (RD_WAIT * CLK_PS >= T_AA_PS);
    a_r10_read_cycle: assert ((RD_WAIT + TURN) * CLK_PS >= T_RC_PS);
    a_r10_float:      assert (TURN >= 1 && TURN * CLK_PS >= T_HZ_PS);
    a_r10_we_width:   assert (WR_PULSE >= 1 && WR_PULSE * CLK_PS >= T_WP_PS);
    a_r10_data_setup: assert (WR_PULSE * CLK_PS >= T_DW_PS);
    a_r10_addr_valid: assert ((WR_PULSE + 1) * CLK_PS >= T_AW_PS);
  end

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ram_cs_n && ram_oe_n && ram_we_n));
  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && !ram_we_n) |=> (ram_cs_n || ram_we_n || $stable(ram_addr)));
  a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n);
  a_r3_cs_before_we: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> $past(!ram_cs_n));
  a_r4_driver_safe: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (ram_oe_n && !ram_cs_n));
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ram_oe_n && $past(!ram_oe_n)));
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind sram_seq sram_seq_chk #(
  .ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE), .TURN(TURN),
  .T_AA_PS(T_AA_PS), .T_RC_PS(T_RC_PS), .T_WP_PS(T_WP_PS), .T_AW_PS(T_AW_PS),
  .T_DW_PS(T_DW_PS), .T_HZ_PS(T_HZ_PS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rd_valid(rd_valid),
  .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .drv_en(drv_en),
  .ram_addr(ram_addr)
);

// File: tb/sram_seq_bench.sv
`timescale 1ns/1ps
module sram_seq_bench;
  localparam int RD_WAIT = 2, WR_PULSE = 1, TURN = 1;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, rd_valid, ram_cs_n, ram_oe_n, ram_we_n;
  logic [7:0] rd_data;
  logic [18:0] ram_addr;
  wire [7:0] ram_dq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sram_seq #(.RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE), .TURN(TURN)) u_sram_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_addr(ram_addr), .ram_dq(ram_dq));

  logic [7:0] mem [int];
  int addr_moves = 0;
  logic prev_ov = 0;
  logic [18:0] prev_addr = '0;

  function automatic logic [7:0] peek(logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  assign ram_dq = (!ram_cs_n && !ram_oe_n && ram_we_n) ? peek(ram_addr) : 8'bz;

  always @(posedge ram_we_n) if (!ram_cs_n) mem[int'(ram_addr)] = ram_dq;

  always @(negedge clk) begin
    if (prev_ov && !ram_cs_n && !ram_we_n && ram_addr != prev_addr) addr_moves++;
    prev_ov   = !ram_cs_n && !ram_we_n;
    prev_addr = ram_addr;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ram_cs_n && ram_oe_n && ram_we_n, "R1 strobes in reset", {ram_cs_n, ram_oe_n, ram_we_n}, 3'b111);
    check(!busy && !done && !rd_valid, "R1 status in reset", {busy, done, rd_valid}, 0);
  endtask

  task automatic t_write(logic [18:0] a, logic [7:0] d);
    int we_low = 0, oe_low = 0, n = 0, wrong_addr = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!done && n < 40) begin
      if (!ram_we_n) we_low++;
      if (!ram_oe_n) oe_low++;
      if (!ram_cs_n && ram_addr != a) wrong_addr++;
      n++;
      @(negedge clk);
    end
    check(we_low == WR_PULSE, "R5 write strobe width", we_low, WR_PULSE);
    check(oe_low == 0, "R3 output enable during write", oe_low, 0);
    check(wrong_addr == 0, "R2 address during write", wrong_addr, 0);
    check(done && n == WR_PULSE + 2, "R9 write done timing", n, WR_PULSE + 2);
    check(peek(a) == d, "R4 stored byte", peek(a), d);
    @(negedge clk);
    check(!done, "R9 done single", done, 0);
  endtask

  task automatic t_read(logic [18:0] a, logic [7:0] exp);
    int n = 0, m = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    while (!rd_valid && n < 40) begin n++; @(negedge clk); end
    check(n == RD_WAIT, "R6 read latency", n, RD_WAIT);
    check(rd_data == exp, "R6 read data", rd_data, exp);
    check(ram_oe_n, "R7 oe released at valid", ram_oe_n, 1);
    @(negedge clk);
    m = 1;
    check(!rd_valid, "R7 valid single cycle", rd_valid, 0);
    while (!done && m < 40) begin m++; @(negedge clk); end
    check(m == TURN, "R9 read done after turnaround", m, TURN);
    @(negedge clk);
  endtask

  task automatic t_busy_ignore;
    int hits = 0, n = 0;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 19'h00123; req_wdata = 8'h11;
    @(negedge clk);
    req_addr = 19'h00456; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 0;
    while (busy && n < 40) begin
      if (!ram_cs_n && ram_addr == 19'h00456) hits++;
      n++; @(negedge clk);
    end
    @(negedge clk);
    check(hits == 0, "R8 no access to ignored address", hits, 0);
    check(!busy && ram_cs_n, "R8 idle after ignored request", busy, 0);
    t_read(19'h00456, 8'h22);
    t_read(19'h00123, 8'h11);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_reset();
        t_write(19'h00456, 8'h22);
        t_read(19'h00456, 8'h22);
        t_write(19'h7FFFF, 8'hA5);
        t_write(19'h00000, 8'h5A);
        t_read(19'h7FFFF, 8'hA5);
        t_read(19'h00000, 8'h5A);
        t_read(19'h3C3C3, 8'h00);
        t_busy_ignore();
        check(addr_moves == 0, "R2 memory model address motion", addr_moves, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule